// File: doc/BRIEF.md
# Tick-Synchronised Register Commit Unit

This unit is the host-facing register front end of a real-time clock whose counters run from a slow one-second tick. The host writes to the time, alarm, interrupt-enable, prescaler and stopwatch registers. Those writes do not land at once. Each one is parked in a single shadow slot, and it is copied into the live register bank on the next tick strobe. Only one parked write can exist at a time. Any further write to a deferred register before that tick is thrown away without notice. Software must therefore poll the pending flag, or wait for the completion flag, before it issues the next deferred write.

The status register works differently. Its clears take effect in the cycle of the bus write. Event strobes from the counter block set their status bits whether or not those events are enabled. The single interrupt line is the OR, over all 16 status positions, of the status bit ANDed with the matching enable bit.

Register addresses: 0 time, 1 alarm, 2 interrupt enable (low 16 bits kept), 3 prescaler, 4 stopwatch, 5 status. Any other address is unused.

Top module: `tick_commit_regs`

## Requirements
- R1: A write to address 0–4 leaves the live registers unchanged until the cycle after the next `sec_tick` high edge. In that cycle the parked value appears on the register outputs and on read-back. Address 2 keeps only `bus_wdata[15:0]`.
- R2: While a write is parked, every write to addresses 0–4 is discarded. This holds even for a different address. The first such write after the commit is accepted.
- R3: Status bit 14 (write pending) reads 1 from the cycle after an accepted deferred write until the cycle after the committing tick. At all other times it reads 0.
- R4: Status bit 15 (write complete) becomes 1 in the cycle after a committing tick and stays 1 until the host clears it.
- R5: A write to address 5 clears at once every status bit whose `bus_wdata` bit is 1. Bit 14 is not affected.
- R6: Event strobe bit i sets status bit i (0 stopwatch, 1 alarm, 2 second, 3 minute, 4 hour, 5 24-hour, 6 day alarm). The bit is set in the next cycle whatever the enable register holds. Status bits 7–13 always read 0.
- R7: `irq` is 1 exactly when some status bit and its matching enable bit are both 1.
- R8: If an event strobe and a clear of the same status bit arrive in one cycle, the bit is set afterwards.
- R9: After reset the status, enable and all live registers read 0, no write is parked, and `irq` is 0.
- R10: A tick with no parked write changes no register and does not set bit 15.
- R11: Writes to address 5 and to unused addresses 6–7 never park a write. Reads of unused addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_waddr | input | AW | Write address |
| bus_wdata | input | DW | Write data |
| bus_raddr | input | AW | Read address |
| bus_rdata | output | DW | Read data (combinational) |
| sec_tick | input | 1 | One-second tick strobe |
| evt_strobe | input | NEVT | Event strobes from the counter block |
| irq | output | 1 | Interrupt request |
| time_val | output | DW | Live time register |
| alarm_val | output | DW | Live alarm register |
| presc_val | output | DW | Live prescaler register |
| swatch_val | output | DW | Live stopwatch register |

## Verification
The bench builds the block with its defaults: 32-bit data, 3-bit addresses and seven event strobes. With 3-bit addresses the two unused addresses can be reached, so discarded writes and zero read-back can be exercised there. With 32-bit data, the trimming of the enable register to 16 bits shows up when a random write sets the upper bits. Ticks are sparse relative to writes, so many writes land while another is parked. This covers both the drop path and the accept-after-commit path, alongside same-cycle strobe and clear collisions.

// File: rtl/rtcw_pkg.sv
package rtcw_pkg;
    // register map
    localparam int NREG    = 5;
    localparam int A_TIME  = 0;
    localparam int A_ALARM = 1;
    localparam int A_IEN   = 2;
    localparam int A_PRESC = 3;
    localparam int A_SWTCH = 4;
    localparam int A_STAT  = 5;
    // status layout
    localparam int SW      = 16;
    localparam int B_PEND  = 14;
    localparam int B_DONE  = 15;
endpackage

// File: rtl/rtcw_commit.sv
module rtcw_commit
    import rtcw_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [DW-1:0]            wr_data,
    input  logic                     tick,
    output logic [NREG-1:0][DW-1:0]  bank_o,
    output logic                     pend_o,
    output logic                     commit_o
);
    localparam logic [DW-1:0] IEN_KEEP = DW'({SW{1'b1}});

    typedef struct packed {
        logic                    pend;
        logic [AW-1:0]           addr;
        logic [DW-1:0]           data;
        logic [NREG-1:0][DW-1:0] bank;
    } cm_st_t;

    cm_st_t st_d, st_q;
    logic   defer_hit, accept, commit;

    always_comb begin
        st_d      = st_q;
        defer_hit = wr_en && (wr_addr < AW'(NREG));
        accept    = defer_hit && !st_q.pend;
        commit    = tick && st_q.pend;
        if (commit) begin
            for (int i = 0; i < NREG; i++) begin
                if (st_q.addr == AW'(i)) st_d.bank[i] = st_q.data;
            end
            st_d.pend = 1'b0;
        end
        if (accept) begin
            st_d.pend = 1'b1;
            st_d.addr = wr_addr;
            st_d.data = (wr_addr == AW'(A_IEN)) ? (wr_data & IEN_KEEP) : wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign bank_o   = st_q.bank;
    assign pend_o   = st_q.pend;
    assign commit_o = commit;

    AST_HOLD_WHILE_PEND: assert property (@(posedge clk) disable iff (rst)
        (st_q.pend && !tick) |=> (st_q.pend && $stable(st_q.data) && $stable(st_q.addr))); // R2
    AST_COMMIT_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (st_q.pend && tick) |=> !st_q.pend); // R3
    AST_ACCEPT_PARKS: assert property (@(posedge clk) disable iff (rst)
        (!st_q.pend && wr_en && (wr_addr < AW'(NREG))) |=> st_q.pend); // R3
    AST_BANK_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!st_q.pend || !tick) |=> $stable(st_q.bank)); // R10
endmodule

// File: rtl/rtcw_status.sv
module rtcw_status
    import rtcw_pkg::*;
#(
    parameter int NEVT = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NEVT-1:0] evt_i,
    input  logic [SW-1:0]   clr_i,
    input  logic            done_i,
    output logic [SW-1:0]   stat_o
);
    localparam logic [SW-1:0] KEEP = SW'((1 << NEVT) - 1) | (SW'(1) << B_DONE);

    typedef struct packed {
        logic [SW-1:0] stat;
    } ss_st_t;

    ss_st_t        st_d, st_q;
    logic [SW-1:0] set_v;

    always_comb begin
        st_d      = st_q;
        set_v     = SW'(evt_i);
        set_v[B_DONE] = done_i;
        st_d.stat = ((st_q.stat & ~clr_i) | set_v) & KEEP;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign stat_o = st_q.stat;

    AST_EVT_LATCH: assert property (@(posedge clk) disable iff (rst)
        (|evt_i) |=> ((st_q.stat[NEVT-1:0] & $past(evt_i)) == $past(evt_i))); // R8
    AST_DONE_SET: assert property (@(posedge clk) disable iff (rst)
        done_i |=> st_q.stat[B_DONE]); // R4
    AST_CLR_NOW: assert property (@(posedge clk) disable iff (rst)
        (clr_i[B_DONE] && !done_i) |=> !st_q.stat[B_DONE]); // R5
endmodule

// File: rtl/rtcw_readout.sv
module rtcw_readout
    import rtcw_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 3
) (
    input  logic [NREG-1:0][DW-1:0] bank_i,
    input  logic [SW-1:0]           stat_i,
    input  logic                    pend_i,
    input  logic [AW-1:0]           raddr_i,
    output logic [DW-1:0]           rdata_o,
    output logic                    irq_o
);
    logic [SW-1:0] full_stat;
    logic [SW-1:0] ien;

    always_comb begin
        full_stat         = stat_i;
        full_stat[B_PEND] = pend_i;
        ien               = bank_i[A_IEN][SW-1:0];
        irq_o             = |(full_stat & ien);
        rdata_o           = '0;
        if (raddr_i == AW'(A_STAT)) begin
            rdata_o = DW'(full_stat);
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (raddr_i == AW'(i)) rdata_o = bank_i[i];
            end
        end
    end
endmodule

// File: rtl/tick_commit_regs.sv
module tick_commit_regs
    import rtcw_pkg::*;
#(
    parameter int DW   = 32,
    parameter int AW   = 3,
    parameter int NEVT = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_waddr,
    input  logic [DW-1:0]   bus_wdata,
    input  logic [AW-1:0]   bus_raddr,
    output logic [DW-1:0]   bus_rdata,
    input  logic            sec_tick,
    input  logic [NEVT-1:0] evt_strobe,
    output logic            irq,
    output logic [DW-1:0]   time_val,
    output logic [DW-1:0]   alarm_val,
    output logic [DW-1:0]   presc_val,
    output logic [DW-1:0]   swatch_val
);
    logic [NREG-1:0][DW-1:0] bank;
    logic                    pend, commit;
    logic [SW-1:0]           stat, clr_mask;

    assign clr_mask = (bus_we && bus_waddr == AW'(A_STAT)) ? bus_wdata[SW-1:0] : '0;

    rtcw_commit #(.DW(DW), .AW(AW)) u_commit (
        .clk(clk), .rst(rst), .wr_en(bus_we), .wr_addr(bus_waddr),
        .wr_data(bus_wdata), .tick(sec_tick), .bank_o(bank),
        .pend_o(pend), .commit_o(commit)
    );

    rtcw_status #(.NEVT(NEVT)) u_status (
        .clk(clk), .rst(rst), .evt_i(evt_strobe), .clr_i(clr_mask),
        .done_i(commit), .stat_o(stat)
    );

    rtcw_readout #(.DW(DW), .AW(AW)) u_readout (
        .bank_i(bank), .stat_i(stat), .pend_i(pend), .raddr_i(bus_raddr),
        .rdata_o(bus_rdata), .irq_o(irq)
    );

    assign time_val   = bank[A_TIME];
    assign alarm_val  = bank[A_ALARM];
    assign presc_val  = bank[A_PRESC];
    assign swatch_val = bank[A_SWTCH];

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq |-> (bank[A_IEN][SW-1:0] != '0)); // R7
    AST_STAT_IGNORES_PEND: assert property (@(posedge clk) disable iff (rst)
        !stat[B_PEND]); // R5
endmodule

// File: tb/tick_commit_regs_bench.sv
module tick_commit_regs_bench;
    localparam int CLK_PER = 10;
    localparam int DW = 32;
    localparam int AW = 3;
    localparam int NE = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          we = 1'b0;
    logic [AW-1:0] waddr = '0;
    logic [DW-1:0] wdata = '0;
    logic [AW-1:0] raddr = 3'd5;
    logic [DW-1:0] rdata;
    logic          tick = 1'b0;
    logic [NE-1:0] evt = '0;
    logic          irq;
    logic [DW-1:0] time_v, alarm_v, presc_v, swatch_v;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [DW-1:0] m_bank [5];
    logic          m_pend;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_data;
    logic [15:0]   m_stat;

    always #(CLK_PER/2) clk = ~clk;

    tick_commit_regs u_tick_commit_regs (
        .clk(clk), .rst(rst), .bus_we(we), .bus_waddr(waddr), .bus_wdata(wdata),
        .bus_raddr(raddr), .bus_rdata(rdata), .sec_tick(tick), .evt_strobe(evt),
        .irq(irq), .time_val(time_v), .alarm_val(alarm_v), .presc_val(presc_v),
        .swatch_val(swatch_v)
    );

    function automatic logic [15:0] exp_stat();
        return m_stat | (m_pend ? 16'h4000 : 16'h0000);
    endfunction

    function automatic logic exp_irq();
        return |(exp_stat() & m_bank[2][15:0]);
    endfunction

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
        if (a == 3'd5) return DW'(exp_stat());
        if (a < 3'd5)  return m_bank[a];
        return '0;
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 5; i++) m_bank[i] = '0;
        m_pend = 0; m_addr = '0; m_data = '0; m_stat = '0;
    endtask

    task automatic model_edge();
        logic          commit, accept;
        logic [15:0]   clr;
        commit = tick && m_pend;
        accept = we && (waddr < 3'd5) && !m_pend;
        clr    = (we && waddr == 3'd5) ? wdata[15:0] : 16'h0;
        m_stat = ((m_stat & ~clr) | 16'(evt) | (commit ? 16'h8000 : 16'h0)) & 16'h807F;
        if (commit) begin
            m_bank[m_addr] = m_data;
            m_pend = 0;
        end
        if (accept) begin
            m_pend = 1;
            m_addr = waddr;
            m_data = (waddr == 3'd2) ? (wdata & 32'h0000FFFF) : wdata;
        end
    endtask

    task automatic check_all();
        chk("R1 time", time_v, m_bank[0]);
        chk("R1 alarm", alarm_v, m_bank[1]);
        chk("R1 prescaler", presc_v, m_bank[3]);
        chk("R1 stopwatch", swatch_v, m_bank[4]);
        chk("R7 irq", DW'(irq), DW'(exp_irq()));
        chk("R11 readback", rdata, exp_read(raddr));
    endtask

    task automatic step(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic t, input logic [NE-1:0] e);
        we = w; waddr = a; wdata = d; tick = t; evt = e;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        we = 0; tick = 0; evt = '0;
        check_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R9 reset state
        chk("R9 status", rdata, 32'h0);
        chk("R9 irq", DW'(irq), 32'h0);
        chk("R9 time", time_v, 32'h0);
        // R1 / R3 / R4 deferred write then commit
        step(1, 3'd0, 32'h1234, 0, '0);
        chk("R1 not yet live", time_v, 32'h0);
        chk("R3 pending", rdata, 32'h4000);
        step(0, 3'd0, 32'h0, 1, '0);
        chk("R1 live after tick", time_v, 32'h1234);
        chk("R4 done set", rdata, 32'h8000);
        step(1, 3'd5, 32'h8000, 0, '0);
        chk("R5 clear done", rdata, 32'h0);
        // R2 second write dropped
        step(1, 3'd1, 32'hAAAA, 0, '0);
        step(1, 3'd0, 32'h5555, 0, '0);
        step(0, 3'd0, 32'h0, 1, '0);
        chk("R2 first kept", alarm_v, 32'hAAAA);
        chk("R2 second dropped", time_v, 32'h1234);
        step(1, 3'd0, 32'h0777, 0, '0);
        chk("R2 accepted after commit", rdata, 32'hC000);
        step(1, 3'd5, 32'hFFFF, 0, '0);
        chk("R5 pending untouched", rdata, 32'h4000);
        step(0, 3'd0, 32'h0, 1, '0);
        chk("R2 later write lands", time_v, 32'h0777);
        step(1, 3'd5, 32'h8000, 0, '0);
        // R10 idle tick
        step(0, 3'd0, 32'h0, 1, '0);
        chk("R10 no done", rdata, 32'h0);
        chk("R10 time held", time_v, 32'h0777);
        // R6 events regardless of enable
        step(0, 3'd0, 32'h0, 0, 7'h7F);
        chk("R6 events", rdata, 32'h007F);
        chk("R7 no irq without enable", DW'(irq), 32'h0);
        step(1, 3'd2, 32'hFFFF0004, 0, '0);
        chk("R7 enable deferred", DW'(irq), 32'h0);
        step(0, 3'd0, 32'h0, 1, '0);
        chk("R7 irq on", DW'(irq), 32'h1);
        raddr = 3'd2;
        #1 chk("R1 enable trimmed", rdata, 32'h0004);
        raddr = 3'd5;
        step(1, 3'd5, 32'h0004, 0, '0);
        chk("R7 irq off", DW'(irq), 32'h0);
        chk("R5 second cleared", rdata, 32'h807B);
        step(1, 3'd5, 32'h0001, 0, 7'h01);
        chk("R8 set wins", rdata, 32'h807B);
        // R11 unused / status writes never park
        step(1, 3'd6, 32'h1234, 0, '0);
        chk("R11 unused addr", rdata, 32'h807B);
        step(1, 3'd5, 32'h0, 0, '0);
        chk("R11 status write no park", rdata, 32'h807B);
        raddr = 3'd7;
        #1 chk("R11 unused read", rdata, 32'h0);
        // random traffic
        for (int n = 0; n < 4000; n++) begin
            logic w, t;
            logic [AW-1:0] a;
            logic [NE-1:0] e;
            w = ($urandom % 5) < 2;
            a = AW'($urandom % 8);
            t = ($urandom % 6) == 0;
            e = NE'($urandom & $urandom & $urandom);
            raddr = AW'($urandom % 8);
            step(w, a, $urandom, t, e);
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule